// File: doc/BRIEF.md
# Four-Operation Rotating Register

This block is a small register of D flip-flops, updated on the rising clock edge, whose next value is picked by a two-bit operation code. The four operations are: keep the current value, force it to zero on the clock edge, invert every bit, or rotate the word one place toward the least significant end. In a rotation the bit that leaves at the bottom re-enters at the top.

A load enable with a data word lets a test or a neighbouring block place any starting value in the register. The load takes precedence over the operation code. An active-low reset clears the register at once, without waiting for a clock.

Inside the block, a control module turns the operation code and the load enable into a set of mutually exclusive strobes. A datapath module applies those strobes to each bit.

Top module: `quad_op_reg`

## Requirements
- R1: While `rstN` is low, `regOut` is 0000. The reset takes effect without a clock edge, whatever the operation code.
- R2: With `loadEn` low and `modeSel` = 2'b00, the register keeps its value across the clock edge.
- R3: With `loadEn` low and `modeSel` = 2'b01, the register becomes 0000 at the next rising edge. It stays unchanged before that edge.
- R4: With `loadEn` low and `modeSel` = 2'b10, every bit of the register is inverted at the rising edge.
- R5: With `loadEn` low and `modeSel` = 2'b11, the register rotates right by one place at the rising edge. Bit 0 moves into bit 3, and bit i+1 moves into bit i.
- R6: When `loadEn` is high, `loadData` is stored at the rising edge, whatever the value of `modeSel`.
- R7: Four rotations in a row return the register to its starting value.
- R8: Two inversions in a row return the register to its starting value.
- R9: Over any sequence of operation codes and loads, `regOut` after each edge equals the value predicted by applying R2 to R6 in order.
- `modeSel[1]` is the first digit of each code above and `modeSel[0]` is the second.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous reset, active low |
| modeSel | input | 2 | Operation code: 00 keep, 01 clear, 10 invert, 11 rotate right |
| loadEn | input | 1 | Parallel load enable; overrides `modeSel` |
| loadData | input | WIDTH (4) | Value stored when `loadEn` is high |
| regOut | output | WIDTH (4) | Current register contents |

## Verification
The clocked properties assume that `modeSel`, `loadEn` and `loadData` are known and steady around each rising edge. Each property compares the register after an edge with the inputs and the register value one cycle earlier, so a glitch or an X at the edge would make that comparison meaningless. The bench honours this by changing inputs only on the falling edge and by driving only 0 or 1 values. The reset check is taken on falling edges while `rstN` is low. Every property is disabled during reset, so the edge on which reset is released is not compared against a pre-reset value.

// File: rtl/quad_op_reg_pkg.sv
package quad_op_reg_pkg;

  typedef enum logic [1:0] {
    OP_KEEP   = 2'b00,
    OP_ZERO   = 2'b01,
    OP_FLIP   = 2'b10,
    OP_ROTATE = 2'b11
  } opCode_e;

  // One-hot update strobes from control to datapath; all low means keep
  typedef struct packed {
    logic load;
    logic zero;
    logic flip;
    logic rotate;
  } regStrobe_t;

endpackage

// File: rtl/quad_op_reg_ctrl.sv
module quad_op_reg_ctrl
  import quad_op_reg_pkg::*;
(
  input  logic       loadEn,
  input  logic [1:0] modeSel,
  output regStrobe_t strobe
);

  opCode_e opCode;

  assign opCode = opCode_e'(modeSel);

  always_comb begin
    strobe = '0;
    if (loadEn) begin
      strobe.load = 1'b1;
    end else begin
      unique case (opCode)
        OP_KEEP:   strobe = '0;
        OP_ZERO:   strobe.zero = 1'b1;
        OP_FLIP:   strobe.flip = 1'b1;
        OP_ROTATE: strobe.rotate = 1'b1;
        default:   strobe = '0;
      endcase
    end
  end

endmodule

// File: rtl/quad_op_reg_datapath.sv
module quad_op_reg_datapath
  import quad_op_reg_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  regStrobe_t       strobe,
  input  logic [WIDTH-1:0] loadData,
  output logic [WIDTH-1:0] regQ
);

  logic [WIDTH-1:0] nextQ;

  // Per-bit next-state selection; the rotate source wraps bit 0 into the top bit
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    localparam int SRC = (i == WIDTH - 1) ? 0 : i + 1;

    always_comb begin
      if (strobe.load)        nextQ[i] = loadData[i];
      else if (strobe.zero)   nextQ[i] = 1'b0;
      else if (strobe.flip)   nextQ[i] = ~regQ[i];
      else if (strobe.rotate) nextQ[i] = regQ[SRC];
      else                    nextQ[i] = regQ[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) regQ <= '0;
    else       regQ <= nextQ;
  end

endmodule

// File: rtl/quad_op_reg.sv
module quad_op_reg
  import quad_op_reg_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       modeSel,
  input  logic             loadEn,
  input  logic [WIDTH-1:0] loadData,
  output logic [WIDTH-1:0] regOut
);

  regStrobe_t strobe;

  quad_op_reg_ctrl u_ctrl (
    .loadEn  (loadEn),
    .modeSel (modeSel),
    .strobe  (strobe)
  );

  quad_op_reg_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .loadData (loadData),
    .regQ     (regOut)
  );

endmodule

// File: rtl/quad_op_reg_chk.sv
module quad_op_reg_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic [1:0]       modeSel,
  input logic             loadEn,
  input logic [WIDTH-1:0] loadData,
  input logic [WIDTH-1:0] regOut
);

  // R1
  always @(negedge clk) begin
    if (!rstN) begin
      reset_zero_chk: assert (regOut == '0);
    end
  end

  // R2
  keep_value_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!loadEn && modeSel == 2'b00) |=> $stable(regOut));

  // R3
  sync_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!loadEn && modeSel == 2'b01) |=> (regOut == '0));

  // R4
  invert_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!loadEn && modeSel == 2'b10) |=> (regOut == ~$past(regOut)));

  // R5
  rotate_right_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!loadEn && modeSel == 2'b11) |=>
      (regOut == {$past(regOut[0]), $past(regOut[WIDTH-1:1])}));

  // R6
  load_priority_chk: assert property (@(posedge clk) disable iff (!rstN)
    loadEn |=> (regOut == $past(loadData)));

endmodule

bind quad_op_reg quad_op_reg_chk #(.WIDTH(WIDTH)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .modeSel  (modeSel),
  .loadEn   (loadEn),
  .loadData (loadData),
  .regOut   (regOut)
);

// File: tb/sim_quad_op_reg.sv
`timescale 1ns/1ps
module sim_quad_op_reg;

  logic       clk = 1'b0;
  logic       rstN = 1'b1;
  logic [1:0] modeSel = 2'b00;
  logic       loadEn = 1'b0;
  logic [3:0] loadData = 4'h0;
  logic [3:0] regOut;

  int checks = 0;
  int errors = 0;
  int model = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  quad_op_reg #(.WIDTH(4)) u0 (
    .clk      (clk),
    .rstN     (rstN),
    .modeSel  (modeSel),
    .loadEn   (loadEn),
    .loadData (loadData),
    .regOut   (regOut)
  );

  task automatic check(input string req, input int expected);
    checks++;
    if (int'(regOut) !== expected) begin
      errors++;
      $display("FAIL %s: regOut=%0d expected=%0d at %0t", req, regOut, expected, $time);
    end
  endtask

  // Behavioural reference for one clock edge
  function automatic int predict(input int cur, input int mode, input bit ld, input int data);
    if (ld) return data;
    case (mode)
      0: return cur;
      1: return 0;
      2: return 15 - cur;
      default: return cur / 2 + (cur % 2) * 8;
    endcase
  endfunction

  // Called on a falling edge: drive, take one rising edge, check on the next falling edge
  task automatic step(input int mode, input bit ld, input int data, input string req);
    modeSel = mode[1:0];
    loadEn = ld;
    loadData = data[3:0];
    model = predict(model, mode, ld, data);
    @(posedge clk);
    @(negedge clk);
    check(req, model);
  endtask

  initial begin
    #3 rstN = 1'b0;
    #2 check("R1", 0);
    @(negedge clk);
    check("R1", 0);
    rstN = 1'b1;
    @(negedge clk);

    step(0, 1'b1, 4'b1011, "R6");
    step(0, 1'b0, 0, "R2");
    step(0, 1'b0, 0, "R2");
    step(3, 1'b0, 0, "R5");          // 1011 -> 1101
    step(2, 1'b0, 0, "R4");          // 1101 -> 0010
    step(3, 1'b1, 4'b0110, "R6");    // load wins over rotate
    step(1, 1'b1, 4'b1001, "R6");    // load wins over clear

    // R3: no change before the edge, zero after it
    modeSel = 2'b01;
    loadEn = 1'b0;
    #1 check("R3", model);
    model = 0;
    @(posedge clk);
    @(negedge clk);
    check("R3", model);

    // R7: four rotations restore the value
    for (int v = 1; v < 16; v += 5) begin
      step(0, 1'b1, v, "R6");
      for (int k = 0; k < 4; k++) step(3, 1'b0, 0, "R5");
      check("R7", v);
    end

    // R8: two inversions restore the value
    for (int v = 0; v < 16; v += 7) begin
      step(0, 1'b1, v, "R6");
      step(2, 1'b0, 0, "R4");
      step(2, 1'b0, 0, "R4");
      check("R8", v);
    end

    // R9: random sequences compared with the reference every clock
    for (int n = 0; n < 400; n++) begin
      step(int'($urandom_range(0, 3)), ($urandom_range(0, 7) == 0),
           int'($urandom_range(0, 15)), "R9");
    end

    // R1: asynchronous reset mid-cycle, whatever the mode
    step(0, 1'b1, 4'b1111, "R6");
    modeSel = 2'b11;
    loadEn = 1'b0;
    #1 rstN = 1'b0;
    #1 check("R1", 0);
    @(negedge clk);
    check("R1", 0);
    rstN = 1'b1;
    model = 0;
    step(2, 1'b0, 0, "R4");          // 0000 -> 1111

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule